// File: doc/BRIEF.md
# Paired-channel threshold monitor

The block stores a set of sample words. Each word carries two 10-bit channel readings. The even channel sits in bits [9:0] and the odd channel sits in bits [25:16]. A read strobe names one pair. The block returns that pair's stored word one cycle later. In the same edge it replaces the stored word with a stepped copy: the even channel rises by 5 and the odd channel by 7, and each wraps within 10 bits.

The stepped values are tested against two bounds words, one for each channel. If either reading lies outside its window, a sticky flag for that pair is set, and the interrupt line rises with it. Software-side logic clears flags through a write-one-to-clear vector. It can also load a sample word through a write port that keeps only the two 10-bit lanes. The number of pairs is a parameter: eight pairs serve sixteen channels, and four pairs serve eight.

Top module: `pair_window_monitor`

## Requirements
- R1: After reset every stored word, every flag, `irq_o` and `rd_data_o` are zero.
- R2: A read of an existing pair presents the stored word on `rd_data_o` on the cycle after the strobe, and `rd_data_o` holds that value until the next read. Only bits [9:0] and [25:16] can ever be non-zero.
- R3: A read that does not collide with a write replaces the stored word. Bits [9:0] become (old even channel + 5) mod 1024, and bits [25:16] become (old odd channel + 7) mod 1024.
- R4: The stepped value of pair k is checked in the same edge. Its even channel is compared with bounds word 2k and its odd channel with bounds word 2k+1. In each bounds word the lower limit is bits [9:0] and the upper limit is bits [25:16]. A channel below its lower limit or above its upper limit sets flag bit k.
- R5: A channel equal to its lower or its upper limit is inside the window and does not set a flag.
- R6: Flags are sticky: a later in-window read leaves them set. `irq_o` is high exactly when any flag is set.
- R7: A one in `flag_clr_i` clears that flag on the next edge, and a zero has no effect. A breach on the same pair in the same cycle wins over its clear.
- R8: A write stores `wr_data_i` masked to bits [9:0] and [25:16] into the addressed pair.
- R9: An index at or above the pair count makes a read return zero and change no word or flag, and makes a write change no word.
- R10: When a write and a read address the same pair in one cycle, the read returns the old word, the written value is stored without stepping, and no breach is evaluated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 1 | Read strobe |
| rd_idx_i | input | IDX_W | Pair index for the read |
| rd_data_o | output | 32 | Word returned by the last read |
| wr_en_i | input | 1 | Sample load strobe |
| wr_idx_i | input | IDX_W | Pair index for the load |
| wr_data_i | input | 32 | Sample word to load (lanes [9:0], [25:16]) |
| bounds_i | input | 64*NUM_PAIRS | Bounds word for channel c at bits [32c+31:32c] |
| flag_clr_i | input | NUM_PAIRS | Write-one-to-clear for the pair flags |
| flags_o | output | NUM_PAIRS | Sticky breach flags, bit k for pair k |
| irq_o | output | 1 | OR of all flags |

## Verification
Some properties are checked on every cycle. These are the per-edge stepping of a read pair, the masked storage of a load, the rule that a flag rises only after a breach strobe and falls only after a clear, and the all-zero result and frozen flags after an out-of-range read, together with the unused bits of `rd_data_o` staying zero. Other behaviour appears only in the directed scenarios. These cover the comparison against concrete limits (the equality corners on both lanes), the lane wrap at 1024, the precedence of a breach over a clear, and the write-read collision, where the stored result only becomes visible through a later read.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CH_W   = 10;
  localparam int unsigned HI_LSB = 16;
  localparam logic [WORD_W-1:0] LANE_MASK = 32'h03FF_03FF;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CH_W-1:0]   lane_t;

  function automatic lane_t lo_lane(word_t w);
    return w[CH_W-1:0];
  endfunction

  function automatic lane_t hi_lane(word_t w);
    return w[HI_LSB +: CH_W];
  endfunction

  function automatic word_t pack_lanes(lane_t lo, lane_t hi);
    word_t w;
    w = '0;
    w[CH_W-1:0] = lo;
    w[HI_LSB +: CH_W] = hi;
    return w;
  endfunction

  // value outside [lower, upper] of a bounds word, limits inclusive
  function automatic logic outside(lane_t v, word_t b);
    return (v < lo_lane(b)) || (v > hi_lane(b));
  endfunction
endpackage

// File: rtl/pwm_sample_bank.sv
module pwm_sample_bank
  import pwm_pkg::*;
#(
  parameter int NUM_PAIRS = 8,
  parameter int IDX_W     = 4,
  parameter int STEP_LO   = 5,
  parameter int STEP_HI   = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_en_i,
  input  logic [IDX_W-1:0]     rd_idx_i,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  word_t                wr_data_i,
  output word_t                cur_word_o,
  output lane_t                adv_lo_o,
  output lane_t                adv_hi_o,
  output logic                 adv_commit_o
);
  localparam int PTR_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;

  word_t            words_q [NUM_PAIRS];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic             rd_hit, wr_hit, collide;

  assign rd_ptr  = rd_idx_i[PTR_W-1:0];
  assign wr_ptr  = wr_idx_i[PTR_W-1:0];
  assign rd_hit  = rd_en_i && (32'(rd_idx_i) < NUM_PAIRS);
  assign wr_hit  = wr_en_i && (32'(wr_idx_i) < NUM_PAIRS);
  assign collide = rd_hit && wr_hit && (rd_ptr == wr_ptr);

  assign cur_word_o   = rd_hit ? words_q[rd_ptr] : '0;
  assign adv_lo_o     = lo_lane(cur_word_o) + lane_t'(STEP_LO);
  assign adv_hi_o     = hi_lane(cur_word_o) + lane_t'(STEP_HI);
  assign adv_commit_o = rd_hit && !collide;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PAIRS; p++) words_q[p] <= '0;
    end else begin
      for (int p = 0; p < NUM_PAIRS; p++) begin
        if (wr_hit && wr_ptr == PTR_W'(p))
          words_q[p] <= wr_data_i & LANE_MASK;
        else if (adv_commit_o && rd_ptr == PTR_W'(p))
          words_q[p] <= pack_lanes(adv_lo_o, adv_hi_o);
      end
    end
  end

  // R3
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && !collide) |=>
      (lo_lane(words_q[$past(rd_ptr)]) == lane_t'(lo_lane($past(cur_word_o)) + lane_t'(STEP_LO))) &&
      (hi_lane(words_q[$past(rd_ptr)]) == lane_t'(hi_lane($past(cur_word_o)) + lane_t'(STEP_HI))));

  // R8
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> words_q[$past(wr_ptr)] == ($past(wr_data_i) & LANE_MASK));
endmodule

// File: rtl/pwm_window_check.sv
module pwm_window_check
  import pwm_pkg::*;
#(
  parameter int NUM_PAIRS = 8
) (
  input  lane_t                          lo_i,
  input  lane_t                          hi_i,
  input  logic [((NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1)-1:0] ptr_i,
  input  logic [2*NUM_PAIRS*WORD_W-1:0]  bounds_i,
  output logic                           breach_o
);
  logic [NUM_PAIRS-1:0] breach_vec;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    word_t b_even, b_odd;
    assign b_even = bounds_i[(2*p)*WORD_W +: WORD_W];
    assign b_odd  = bounds_i[(2*p+1)*WORD_W +: WORD_W];
    assign breach_vec[p] = outside(lo_i, b_even) || outside(hi_i, b_odd);
  end

  assign breach_o = breach_vec[ptr_i];
endmodule

// File: rtl/pwm_flag_reg.sv
module pwm_flag_reg #(
  parameter int NUM_PAIRS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_i,
  input  logic [((NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1)-1:0] set_ptr_i,
  input  logic [NUM_PAIRS-1:0] clr_i,
  output logic [NUM_PAIRS-1:0] flags_o
);
  logic [NUM_PAIRS-1:0] flags_q, set_mask;

  assign set_mask = set_i ? (NUM_PAIRS'(1) << set_ptr_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_i) | set_mask;
  end

  assign flags_o = flags_q;

  // R4
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flags_q & ~$past(flags_q))) |-> $past(set_i));

  // R6
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(flags_q) & ~flags_q & ~$past(clr_i)) == '0));
endmodule

// File: rtl/pair_window_monitor.sv
module pair_window_monitor
  import pwm_pkg::*;
#(
  parameter int NUM_PAIRS = 8,
  parameter int IDX_W     = 4,
  parameter int STEP_LO   = 5,
  parameter int STEP_HI   = 7
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          rd_en_i,
  input  logic [IDX_W-1:0]              rd_idx_i,
  output logic [31:0]                   rd_data_o,
  input  logic                          wr_en_i,
  input  logic [IDX_W-1:0]              wr_idx_i,
  input  logic [31:0]                   wr_data_i,
  input  logic [2*NUM_PAIRS*32-1:0]     bounds_i,
  input  logic [NUM_PAIRS-1:0]          flag_clr_i,
  output logic [NUM_PAIRS-1:0]          flags_o,
  output logic                          irq_o
);
  localparam int PTR_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;

  word_t cur_word, rd_data_q;
  lane_t adv_lo, adv_hi;
  logic  adv_commit, breach;

  pwm_sample_bank #(
    .NUM_PAIRS (NUM_PAIRS),
    .IDX_W     (IDX_W),
    .STEP_LO   (STEP_LO),
    .STEP_HI   (STEP_HI)
  ) u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_en_i      (rd_en_i),
    .rd_idx_i     (rd_idx_i),
    .wr_en_i      (wr_en_i),
    .wr_idx_i     (wr_idx_i),
    .wr_data_i    (wr_data_i),
    .cur_word_o   (cur_word),
    .adv_lo_o     (adv_lo),
    .adv_hi_o     (adv_hi),
    .adv_commit_o (adv_commit)
  );

  pwm_window_check #(.NUM_PAIRS(NUM_PAIRS)) u_check (
    .lo_i     (adv_lo),
    .hi_i     (adv_hi),
    .ptr_i    (rd_idx_i[PTR_W-1:0]),
    .bounds_i (bounds_i),
    .breach_o (breach)
  );

  pwm_flag_reg #(.NUM_PAIRS(NUM_PAIRS)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (adv_commit && breach),
    .set_ptr_i (rd_idx_i[PTR_W-1:0]),
    .clr_i     (flag_clr_i),
    .flags_o   (flags_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_q <= '0;
    else if (rd_en_i) rd_data_q <= cur_word;
  end

  assign rd_data_o = rd_data_q;
  assign irq_o     = |flags_o;

  // R9
  oor_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (32'(rd_idx_i) >= NUM_PAIRS) && (flag_clr_i == '0)) |=>
      (rd_data_o == '0) && $stable(flags_o));

  // R2
  lane_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~LANE_MASK) == '0);
endmodule

// File: tb/tb_pair_window_monitor.sv
`timescale 1ns/1ps
module tb_pair_window_monitor;
  localparam int NP    = 8;
  localparam int IW    = 4;
  localparam int NCH   = 2 * NP;
  localparam logic [31:0] WIDE = 32'h03FF_0000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rd_en = 1'b0;
  logic [IW-1:0]     rd_idx = '0;
  logic [31:0]       rd_data;
  logic              wr_en = 1'b0;
  logic [IW-1:0]     wr_idx = '0;
  logic [31:0]       wr_data = '0;
  logic [NCH*32-1:0] bounds;
  logic [NP-1:0]     clr = '0;
  logic [NP-1:0]     flags;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pair_window_monitor #(.NUM_PAIRS(NP), .IDX_W(IW)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .rd_en_i    (rd_en),
    .rd_idx_i   (rd_idx),
    .rd_data_o  (rd_data),
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_data_i  (wr_data),
    .bounds_i   (bounds),
    .flag_clr_i (clr),
    .flags_o    (flags),
    .irq_o      (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle of stimulus driven at negedge; results readable on return
  task automatic op(input bit r, input int ri, input bit w, input int wi,
                    input logic [31:0] wd, input logic [NP-1:0] c);
    @(negedge clk);
    rd_en = r; rd_idx = IW'(ri);
    wr_en = w; wr_idx = IW'(wi); wr_data = wd;
    clr = c;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0; clr = '0;
  endtask

  task automatic rd(input int i);  op(1'b1, i, 1'b0, 0, '0, '0); endtask
  task automatic wr(input int i, input logic [31:0] d); op(1'b0, 0, 1'b1, i, d, '0); endtask
  task automatic clear(input logic [NP-1:0] c); op(1'b0, 0, 1'b0, 0, '0, c); endtask

  task automatic t_reset();
    chk("R1 flags", 32'(flags), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 rd_data", rd_data, 32'h0);
  endtask

  task automatic t_advance();
    rd(0); chk("R1 first read of pair0", rd_data, 32'h0);
    rd(0); chk("R3 step once", rd_data, 32'h0007_0005);
    rd(0); chk("R3 step twice", rd_data, 32'h000E_000A);
    chk("R2 hold without strobe", rd_data, 32'h000E_000A);
    chk("R4 no breach in wide window", 32'(flags), 32'h0);
  endtask

  task automatic t_wrap_mask();
    wr(1, 32'h03FC_03FE);
    rd(1); chk("R8 loaded word", rd_data, 32'h03FC_03FE);
    rd(1); chk("R3 lanes wrap mod 1024", rd_data, 32'h0003_0003);
    wr(2, 32'hFFFF_FFFF);
    rd(2); chk("R8 load masked to lanes", rd_data, 32'h03FF_03FF);
  endtask

  task automatic t_window();
    bounds[6*32 +: 32] = 32'h00C8_0064;  // even lane of pair3: [100,200]
    bounds[7*32 +: 32] = 32'h0032_0000;  // odd lane of pair3: [0,50]
    wr(3, 32'h0000_005F); rd(3);
    chk("R2 read returns old word", rd_data, 32'h0000_005F);
    chk("R5 even lane at lower limit", 32'(flags), 32'h0);
    wr(3, 32'h002B_00C3); rd(3);
    chk("R5 both lanes at upper limit", 32'(flags), 32'h0);
    chk("R6 irq low with no flag", 32'(irq), 32'h0);
    wr(3, 32'h002B_00C4); rd(3);
    chk("R4 even lane above upper", 32'(flags), 32'h08);
    chk("R6 irq follows flag", 32'(irq), 32'h1);
    wr(3, 32'h0000_0096); rd(3);
    chk("R6 flag sticky after in-window read", 32'(flags), 32'h08);
    clear(8'hF7);
    chk("R7 zero clear bit has no effect", 32'(flags), 32'h08);
    clear(8'h08);
    chk("R7 flag cleared", 32'(flags), 32'h0);
    chk("R6 irq low after clear", 32'(irq), 32'h0);
    wr(3, 32'h0000_005E); rd(3);
    chk("R4 even lane below lower", 32'(flags), 32'h08);
    clear(8'h08);
    wr(3, 32'h002C_0096); rd(3);
    chk("R4 odd lane above upper", 32'(flags), 32'h08);
    clear(8'h08);
    wr(3, 32'h002C_0096);
    op(1'b1, 3, 1'b0, 0, '0, 8'h08);
    chk("R7 breach wins over same-cycle clear", 32'(flags), 32'h08);
    clear(8'h08);
  endtask

  task automatic t_collide();
    bounds[8*32 +: 32] = 32'h03FF_000A;  // pair4 even lane: [10,1023]
    op(1'b1, 4, 1'b1, 4, 32'h0011_0022, '0);
    chk("R10 collision returns old word", rd_data, 32'h0);
    chk("R10 no breach evaluated", 32'(flags), 32'h0);
    rd(4); chk("R10 written word stored unstepped", rd_data, 32'h0011_0022);
  endtask

  task automatic t_oor();
    rd(4); chk("R3 pair4 stepped", rd_data, 32'h0018_0027);
    rd(12); chk("R9 out-of-range read returns zero", rd_data, 32'h0);
    chk("R9 flags untouched", 32'(flags), 32'h0);
    wr(12, 32'h0123_0123);
    rd(4); chk("R9 aliasing pair not advanced or written", rd_data, 32'h001F_002C);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) bounds[c*32 +: 32] = WIDE;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_advance();
    t_wrap_mask();
    t_window();
    t_collide();
    t_oor();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule